// File: doc/BRIEF.md
# Depth-Stencil Interleave Box Walker

This block walks a three-dimensional box (width in pixels, height in rows, depth in slices) and emits one byte-lane copy command per pixel. Each command pairs a position on a depth surface with a position on a separate 8-bit stencil surface and a byte address in a packed linear staging buffer. In the read direction the consumer gathers the depth bytes and the stencil byte into one staging pixel. In the write direction it scatters a staging pixel back into the two surfaces. The walker only produces plane coordinates (byte column, row). Tiled address translation and the memory traffic belong to downstream logic.

A start pulse captures the box extent, the format, the direction and the staging base and strides. At the start of every slice the walker presents the slice index on `org_slice` and samples that slice's origin for each plane from the origin inputs. Commands leave on a valid/ready handshake. A one-cycle `done` pulse follows the last accepted command.

Top module: `zs_box_walker`

## Requirements
- R1: After reset, and whenever the walker is idle, `busy`, `done` and `cmd_valid` are all low.
- R2: With `fmt` = 0 (24-bit depth plus stencil) every staging pixel spans 4 bytes, `cmd_dep_len` is 3 and `cmd_stn_lane` is 3.
- R3: With `fmt` = 1 (32-bit float depth plus stencil) every staging pixel spans 8 bytes, `cmd_dep_len` is 4 and `cmd_stn_lane` is 4.
- R4: With `fmt` = 2 or 3 (stencil only) every staging pixel spans 1 byte, `cmd_dep_len` and `cmd_stn_lane` are 0, and `cmd_dep_x` and `cmd_dep_y` read 0.
- R5: Commands come in slice-major, then row, then pixel order. The staging address of pixel c in row r of slice s is base + s·layer_stride + r·row_stride + c·pixel_bytes.
- R6: Within a row the depth byte column rises by 4 per pixel and the stencil column by 1. Each new row raises both plane rows by 1 and restarts both columns at the slice origin.
- R7: While slice s is being set up, `org_slice` equals s. Every pixel of slice s takes its plane coordinates relative to the origins presented for s.
- R8: While `cmd_valid` is high and `cmd_ready` is low, the command stays valid and all of its fields stay unchanged.
- R9: `cmd_last` marks only the final pixel of the box. `done` is high for exactly the one cycle that follows the acceptance of that command.
- R10: A start with a zero width, height or depth produces `done` in the next cycle and no command.
- R11: A start pulse while `busy` is high has no effect on the command stream in progress.
- R12: `cmd_dir` repeats the direction captured at start on every command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| dir | input | 1 | 0 = pack planes into staging, 1 = unpack staging into planes |
| fmt | input | 2 | 0 = 24-bit depth + stencil, 1 = 32-bit float depth + stencil, 2/3 = stencil only |
| box_w | input | DIM_W | Box width in pixels |
| box_h | input | DIM_W | Box height in rows |
| box_d | input | DIM_W | Box depth in slices |
| stg_base | input | ADR_W | Staging byte address of the first pixel |
| stg_row_stride | input | ADR_W | Staging bytes between rows |
| stg_layer_stride | input | ADR_W | Staging bytes between slices |
| org_slice | output | DIM_W | Slice whose origins are requested |
| dep_org_x | input | CRD_W | Depth plane byte column origin for `org_slice` |
| dep_org_y | input | CRD_W | Depth plane row origin for `org_slice` |
| stn_org_x | input | CRD_W | Stencil plane column origin for `org_slice` |
| stn_org_y | input | CRD_W | Stencil plane row origin for `org_slice` |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Consumer accepts the command |
| cmd_dir | output | 1 | Direction of this copy |
| cmd_last | output | 1 | Final pixel of the box |
| cmd_stg_addr | output | ADR_W | Staging byte address of the pixel |
| cmd_dep_x | output | CRD_W | Depth plane byte column |
| cmd_dep_y | output | CRD_W | Depth plane row |
| cmd_dep_len | output | 3 | Depth bytes to copy |
| cmd_stn_x | output | CRD_W | Stencil plane column |
| cmd_stn_y | output | CRD_W | Stencil plane row |
| cmd_stn_lane | output | 3 | Byte position of stencil within the staging pixel |

## Verification
The bench sweeps every format and direction over boxes of one to three pixels, one to three rows and one to two slices, with a consumer that alternates between always-ready and pseudo-random back-pressure. The row and slice wraps are the main targets. A walker that restarted the row from the running column instead of the slice origin, or that missed the layer stride on a slice change, would emit wrong plane or staging addresses on the first pixel of a new row or slice. Stalls check that a command held under back-pressure does not drift. Mid-walk start pulses carrying a zero extent and a different format check that the captured parameters stay fixed. Zero-extent boxes and the exact cycle of `done` check that the walker neither emits a stray command nor closes one cycle early or late.

// File: rtl/zs_walk_pkg.sv
package zs_walk_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_LOAD = 2'd1,
    WS_RUN  = 2'd2,
    WS_FIN  = 2'd3
  } walk_state_t;

  typedef struct packed {
    logic       has_dep;
    logic [3:0] pix_bytes;
    logic [2:0] dep_len;
    logic [2:0] stn_lane;
    logic [2:0] dep_step;
  } fmt_info_t;

  // staging pixel size in bytes for a format code
  function automatic logic [3:0] fn_pix_bytes(input logic [1:0] f);
    case (f)
      2'd0:    fn_pix_bytes = 4'd4;
      2'd1:    fn_pix_bytes = 4'd8;
      default: fn_pix_bytes = 4'd1;
    endcase
  endfunction

  // depth bytes carried per pixel
  function automatic logic [2:0] fn_dep_len(input logic [1:0] f);
    case (f)
      2'd0:    fn_dep_len = 3'd3;
      2'd1:    fn_dep_len = 3'd4;
      default: fn_dep_len = 3'd0;
    endcase
  endfunction

  // staging byte that holds the stencil value
  function automatic logic [2:0] fn_stn_lane(input logic [1:0] f);
    case (f)
      2'd0:    fn_stn_lane = 3'd3;
      2'd1:    fn_stn_lane = 3'd4;
      default: fn_stn_lane = 3'd0;
    endcase
  endfunction

  // depth plane bytes per pixel (column advance)
  function automatic logic [2:0] fn_dep_step(input logic [1:0] f);
    fn_dep_step = (f[1] == 1'b0) ? 3'd4 : 3'd0;
  endfunction

endpackage

// File: rtl/zs_fmt_decode.sv
module zs_fmt_decode
  import zs_walk_pkg::*;
(
  input  logic [1:0] fmt,
  output fmt_info_t  info
);
  always_comb begin
    info.has_dep   = ~fmt[1];
    info.pix_bytes = fn_pix_bytes(fmt);
    info.dep_len   = fn_dep_len(fmt);
    info.stn_lane  = fn_stn_lane(fmt);
    info.dep_step  = fn_dep_step(fmt);
  end
endmodule

// File: rtl/zs_loop_ctr.sv
module zs_loop_ctr #(
  parameter int DIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [DIM_W-1:0] lim_w,
  input  logic [DIM_W-1:0] lim_h,
  input  logic [DIM_W-1:0] lim_d,
  output logic [DIM_W-1:0] col,
  output logic [DIM_W-1:0] row,
  output logic [DIM_W-1:0] slc,
  output logic             col_last,
  output logic             row_last,
  output logic             slc_last
);
  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  assign col_last = (col == lim_w - ONE);
  assign row_last = (row == lim_h - ONE);
  assign slc_last = (slc == lim_d - ONE);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      col <= '0;
      row <= '0;
      slc <= '0;
    end else if (adv) begin
      if (!col_last) begin
        col <= col + ONE;
      end else begin
        col <= '0;
        if (!row_last) begin
          row <= row + ONE;
        end else begin
          row <= '0;
          slc <= slc_last ? '0 : slc + ONE;
        end
      end
    end
  end
endmodule

// File: rtl/zs_coord_acc.sv
module zs_coord_acc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step_col,
  input  logic         step_row,
  input  logic [W-1:0] col_inc,
  input  logic [W-1:0] row_inc,
  output logic [W-1:0] cur
);
  logic [W-1:0] row_start;
  logic [W-1:0] next_row;

  assign next_row = row_start + row_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur       <= '0;
      row_start <= '0;
    end else if (load) begin
      cur       <= load_val;
      row_start <= load_val;
    end else if (step_row) begin
      cur       <= next_row;
      row_start <= next_row;
    end else if (step_col) begin
      cur <= cur + col_inc;
    end
  end
endmodule

// File: rtl/zs_box_walker.sv
module zs_box_walker
  import zs_walk_pkg::*;
#(
  parameter int DIM_W = 8,
  parameter int CRD_W = 16,
  parameter int ADR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic [1:0]       fmt,
  input  logic [DIM_W-1:0] box_w,
  input  logic [DIM_W-1:0] box_h,
  input  logic [DIM_W-1:0] box_d,
  input  logic [ADR_W-1:0] stg_base,
  input  logic [ADR_W-1:0] stg_row_stride,
  input  logic [ADR_W-1:0] stg_layer_stride,
  output logic [DIM_W-1:0] org_slice,
  input  logic [CRD_W-1:0] dep_org_x,
  input  logic [CRD_W-1:0] dep_org_y,
  input  logic [CRD_W-1:0] stn_org_x,
  input  logic [CRD_W-1:0] stn_org_y,
  output logic             busy,
  output logic             done,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic             cmd_dir,
  output logic             cmd_last,
  output logic [ADR_W-1:0] cmd_stg_addr,
  output logic [CRD_W-1:0] cmd_dep_x,
  output logic [CRD_W-1:0] cmd_dep_y,
  output logic [2:0]       cmd_dep_len,
  output logic [CRD_W-1:0] cmd_stn_x,
  output logic [CRD_W-1:0] cmd_stn_y,
  output logic [2:0]       cmd_stn_lane
);
  localparam int NPL = 4;              // plane coordinate channels
  localparam int IDX_DX = 0;
  localparam int IDX_DY = 1;
  localparam int IDX_SX = 2;
  localparam int IDX_SY = 3;
  localparam logic [CRD_W-1:0] C_ONE = CRD_W'(1);

  walk_state_t state, state_nxt;

  fmt_info_t        info_in, r_info;
  logic             r_dir;
  logic [DIM_W-1:0] r_w, r_h, r_d;
  logic [ADR_W-1:0] r_row_stride, r_layer_stride, r_slice_base;

  logic [DIM_W-1:0] col, row, slc;
  logic             col_last, row_last, slc_last;

  // named internal events (also observed by the checker)
  logic start_take, zero_box, hs;
  logic ev_col_step, ev_row_step, ev_slice_step, ev_box_end, ev_load;

  zs_fmt_decode u_dec (.fmt(fmt), .info(info_in));

  assign zero_box      = (box_w == '0) || (box_h == '0) || (box_d == '0);
  assign start_take    = start && (state == WS_IDLE);
  assign hs            = cmd_valid && cmd_ready;
  assign ev_col_step   = hs && !col_last;
  assign ev_row_step   = hs && col_last && !row_last;
  assign ev_slice_step = hs && col_last && row_last && !slc_last;
  assign ev_box_end    = hs && col_last && row_last && slc_last;
  assign ev_load       = (state == WS_LOAD);

  always_comb begin
    state_nxt = state;
    case (state)
      WS_IDLE: if (start_take) state_nxt = zero_box ? WS_FIN : WS_LOAD;
      WS_LOAD: state_nxt = WS_RUN;
      WS_RUN: begin
        if (ev_slice_step)   state_nxt = WS_LOAD;
        else if (ev_box_end) state_nxt = WS_FIN;
      end
      default: state_nxt = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= WS_IDLE;
    else        state <= state_nxt;
  end

  // parameter capture and per-slice staging base
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_info         <= '0;
      r_dir          <= 1'b0;
      r_w            <= '0;
      r_h            <= '0;
      r_d            <= '0;
      r_row_stride   <= '0;
      r_layer_stride <= '0;
      r_slice_base   <= '0;
    end else if (start_take) begin
      r_info         <= info_in;
      r_dir          <= dir;
      r_w            <= box_w;
      r_h            <= box_h;
      r_d            <= box_d;
      r_row_stride   <= stg_row_stride;
      r_layer_stride <= stg_layer_stride;
      r_slice_base   <= stg_base;
    end else if (ev_slice_step) begin
      r_slice_base   <= r_slice_base + r_layer_stride;
    end
  end

  zs_loop_ctr #(.DIM_W(DIM_W)) u_loop (
    .clk(clk), .rst_n(rst_n), .clear(start_take), .adv(hs),
    .lim_w(r_w), .lim_h(r_h), .lim_d(r_d),
    .col(col), .row(row), .slc(slc),
    .col_last(col_last), .row_last(row_last), .slc_last(slc_last)
  );

  // plane coordinate channels
  logic [CRD_W-1:0] pl_org  [NPL];
  logic [CRD_W-1:0] pl_cinc [NPL];
  logic [CRD_W-1:0] pl_rinc [NPL];
  logic [CRD_W-1:0] pl_cur  [NPL];

  assign pl_org[IDX_DX]  = dep_org_x;
  assign pl_org[IDX_DY]  = dep_org_y;
  assign pl_org[IDX_SX]  = stn_org_x;
  assign pl_org[IDX_SY]  = stn_org_y;
  assign pl_cinc[IDX_DX] = {{(CRD_W-3){1'b0}}, r_info.dep_step};
  assign pl_cinc[IDX_DY] = '0;
  assign pl_cinc[IDX_SX] = C_ONE;
  assign pl_cinc[IDX_SY] = '0;
  assign pl_rinc[IDX_DX] = '0;
  assign pl_rinc[IDX_DY] = C_ONE;
  assign pl_rinc[IDX_SX] = '0;
  assign pl_rinc[IDX_SY] = C_ONE;

  for (genvar g = 0; g < NPL; g++) begin : g_plane
    zs_coord_acc #(.W(CRD_W)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .load(ev_load), .load_val(pl_org[g]),
      .step_col(ev_col_step), .step_row(ev_row_step),
      .col_inc(pl_cinc[g]), .row_inc(pl_rinc[g]),
      .cur(pl_cur[g])
    );
  end

  // staging address channel
  logic [ADR_W-1:0] stg_cinc;
  assign stg_cinc = {{(ADR_W-4){1'b0}}, r_info.pix_bytes};

  zs_coord_acc #(.W(ADR_W)) u_stg (
    .clk(clk), .rst_n(rst_n),
    .load(ev_load), .load_val(r_slice_base),
    .step_col(ev_col_step), .step_row(ev_row_step),
    .col_inc(stg_cinc), .row_inc(r_row_stride),
    .cur(cmd_stg_addr)
  );

  // outputs
  assign org_slice    = slc;
  assign busy         = (state != WS_IDLE);
  assign done         = (state == WS_FIN);
  assign cmd_valid    = (state == WS_RUN);
  assign cmd_dir      = r_dir;
  assign cmd_last     = col_last && row_last && slc_last;
  assign cmd_dep_x    = r_info.has_dep ? pl_cur[IDX_DX] : '0;
  assign cmd_dep_y    = r_info.has_dep ? pl_cur[IDX_DY] : '0;
  assign cmd_stn_x    = pl_cur[IDX_SX];
  assign cmd_stn_y    = pl_cur[IDX_SY];
  assign cmd_dep_len  = r_info.dep_len;
  assign cmd_stn_lane = r_info.stn_lane;

endmodule

// File: rtl/zs_box_walker_chk.sv
module zs_box_walker_chk #(
  parameter int CRD_W = 16,
  parameter int ADR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             zero_box,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_last,
  input logic [ADR_W-1:0] cmd_stg_addr,
  input logic [CRD_W-1:0] cmd_dep_x,
  input logic [CRD_W-1:0] cmd_stn_x,
  input logic [CRD_W-1:0] cmd_stn_y,
  input logic [2:0]       cmd_dep_len,
  input logic [2:0]       cmd_stn_lane,
  input logic             ev_col_step,
  input logic             ev_row_step
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cmd_valid && !done)); // R1

  AST_LANE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_stn_lane == cmd_dep_len)); // R2

  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_stg_addr)
      && $stable(cmd_dep_x) && $stable(cmd_stn_x) && $stable(cmd_stn_y))); // R8

  AST_STN_COL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_col_step |=> (cmd_stn_x == $past(cmd_stn_x) + CRD_W'(1))); // R6

  AST_STN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_row_step |=> (cmd_stn_y == $past(cmd_stn_y) + CRD_W'(1))); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_last) |=> (done && !cmd_valid)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_ZERO_BOX: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && zero_box) |=> (done && !cmd_valid)); // R10
endmodule

bind zs_box_walker zs_box_walker_chk #(.CRD_W(CRD_W), .ADR_W(ADR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .zero_box(zero_box), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_last(cmd_last), .cmd_stg_addr(cmd_stg_addr), .cmd_dep_x(cmd_dep_x),
  .cmd_stn_x(cmd_stn_x), .cmd_stn_y(cmd_stn_y), .cmd_dep_len(cmd_dep_len),
  .cmd_stn_lane(cmd_stn_lane), .ev_col_step(ev_col_step),
  .ev_row_step(ev_row_step)
);

// File: tb/tb_zs_box_walker.sv
`timescale 1ns/1ps
module tb_zs_box_walker;
  localparam int DIM_W = 8;
  localparam int CRD_W = 16;
  localparam int ADR_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir = 1'b0, cmd_ready = 1'b0;
  logic [1:0] fmt = '0;
  logic [DIM_W-1:0] box_w = '0, box_h = '0, box_d = '0;
  logic [ADR_W-1:0] stg_base = '0, stg_row_stride = '0, stg_layer_stride = '0;
  logic [DIM_W-1:0] org_slice;
  logic [CRD_W-1:0] dep_org_x, dep_org_y, stn_org_x, stn_org_y;
  logic busy, done, cmd_valid, cmd_dir, cmd_last;
  logic [ADR_W-1:0] cmd_stg_addr;
  logic [CRD_W-1:0] cmd_dep_x, cmd_dep_y, cmd_stn_x, cmd_stn_y;
  logic [2:0] cmd_dep_len, cmd_stn_lane;

  int checks = 0;
  int errors = 0;
  logic [7:0] lfsr = 8'h5a;

  always #2 clk = ~clk;

  function automatic int o_dx(int s); return s * 40 + 8; endfunction
  function automatic int o_dy(int s); return s * 3 + 1;  endfunction
  function automatic int o_sx(int s); return s * 11 + 2; endfunction
  function automatic int o_sy(int s); return s * 5 + 7;  endfunction

  always_comb begin
    dep_org_x = CRD_W'(o_dx(int'(org_slice)));
    dep_org_y = CRD_W'(o_dy(int'(org_slice)));
    stn_org_x = CRD_W'(o_sx(int'(org_slice)));
    stn_org_y = CRD_W'(o_sy(int'(org_slice)));
  end

  zs_box_walker #(.DIM_W(DIM_W), .CRD_W(CRD_W), .ADR_W(ADR_W)) dut (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one walk; rdy_mode 0 = always ready, 1 = pseudo-random back-pressure
  task automatic walk(input int f, input int d_in, input int w, input int h,
                      input int d, input int rdy_mode, input bit inj);
    int pb, dl, ds, base, rs, ls, guard, iter;
    bit held;
    longint held_addr;
    string tlen;
    pb = (f == 0) ? 4 : (f == 1) ? 8 : 1;
    dl = (f == 0) ? 3 : (f == 1) ? 4 : 0;
    ds = (f < 2) ? 4 : 0;
    tlen = (f == 0) ? "R2" : (f == 1) ? "R3" : "R4";
    base = 100 + f * 7; rs = 64; ls = 512;
    @(negedge clk);
    fmt = 2'(f); dir = d_in[0]; box_w = 8'(w); box_h = 8'(h); box_d = 8'(d);
    stg_base = 24'(base); stg_row_stride = 24'(rs); stg_layer_stride = 24'(ls);
    start = 1'b1; cmd_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    iter = 0; held = 1'b0; held_addr = 0;
    for (int s = 0; s < d; s++) begin
      for (int r = 0; r < h; r++) begin
        for (int c = 0; c < w; c++) begin
          guard = 0;
          forever begin
            iter++;
            if (inj && iter == 4) begin
              start = 1'b1; box_w = '0; fmt = ~2'(f);
            end else begin
              start = 1'b0; box_w = 8'(w); fmt = 2'(f);
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cmd_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
            #1;
            if (held && cmd_valid) chk("R8 stall hold", cmd_stg_addr, held_addr);
            held = cmd_valid && !cmd_ready;
            held_addr = cmd_stg_addr;
            if (cmd_valid && cmd_ready) break;
            guard++;
            if (guard > 50) begin
              chk("R5 command missing", 0, 1);
              return;
            end
            @(negedge clk);
          end
          chk(inj ? "R11 staging addr" : "R5 staging addr", cmd_stg_addr,
              base + s * ls + r * rs + c * pb);
          chk("R6 depth col", cmd_dep_x, (f < 2) ? o_dx(s) + c * ds : 0);
          chk("R7 depth row", cmd_dep_y, (f < 2) ? o_dy(s) + r : 0);
          chk("R6 stencil col", cmd_stn_x, o_sx(s) + c);
          chk("R7 stencil row", cmd_stn_y, o_sy(s) + r);
          chk(tlen, cmd_dep_len, dl);
          chk(tlen, cmd_stn_lane, dl);
          chk("R12 dir", cmd_dir, d_in);
          chk("R9 last flag", cmd_last, (s == d-1 && r == h-1 && c == w-1) ? 1 : 0);
          @(negedge clk);
        end
      end
    end
    start = 1'b0; cmd_ready = 1'b0;
    #1;
    chk("R9 done after last", {cmd_valid, done}, 2'b01);
    @(negedge clk); #1;
    chk("R9 done single", {busy, done}, 2'b00);
  endtask

  task automatic zero_walk(input int w, input int h, input int d);
    @(negedge clk);
    box_w = 8'(w); box_h = 8'(h); box_d = 8'(d); fmt = 2'd0;
    start = 1'b1; cmd_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk("R10 zero box done", {cmd_valid, done}, 2'b01);
    @(negedge clk); #1;
    chk("R10 no command", {cmd_valid, busy}, 2'b00);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset state", {busy, done, cmd_valid}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 idle state", {busy, done, cmd_valid}, 3'b000);
    for (int f = 0; f < 4; f++)
      for (int dd = 0; dd < 2; dd++)
        for (int w = 1; w <= 3; w++)
          for (int h = 1; h <= 3; h++)
            for (int d = 1; d <= 2; d++)
              walk(f, dd, w, h, d, (w + h + d) % 2, (w == 3 && h == 2));
    zero_walk(0, 2, 2);
    zero_walk(2, 0, 2);
    zero_walk(2, 2, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule